// File: doc/BRIEF.md
# Serial Multi-Operand Adder Slice

This block adds a group of NUM_OPS unsigned operands with a single accumulator instead of a tree of two-input adders. A load strobe arrives at the slow sample rate. On that strobe a parallel-to-serial stage takes all operands at once. It then hands the accumulator one operand per fast clock cycle. After NUM_OPS fast cycles the total appears on a registered output, together with a one-cycle valid pulse.

The whole block runs on one fast clock. The slow sample rate is represented by the load strobe, which is expected once every NUM_OPS cycles. That ratio is what allows one accumulator to keep pace with a full group of parallel adders. To cover a large multi-operand sum, several of these slices are placed side by side, one slice per group of operands. Their partial totals are then combined downstream.

Top module: `serial_moa`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, valid_o is 0 and sum_o is 0.
- R2: Operand k is taken from bits [k*OP_W +: OP_W] of ops_i. Each frame reports the exact unsigned sum of all NUM_OPS operands. The sum is OP_W+clog2(NUM_OPS) bits wide, so even all-ones operands cannot overflow it.
- R3: A load sampled on a clock edge while the block accepts loads starts a frame. valid_o is then high for exactly one cycle, in the cycle after the NUM_OPS-th following clock edge. At no other time is valid_o high.
- R4: sum_o holds its value whenever valid_o is low.
- R5: A load that arrives during a frame, except in the frame's last cycle, is ignored. The running frame's result and timing are unchanged, and no extra valid pulse follows.
- R6: A load in the last cycle of a frame is accepted. Loads every NUM_OPS cycles therefore produce valid pulses every NUM_OPS cycles with no gap.
- R7: After the loading edge, changes on ops_i do not affect that frame's result.
- R8: Each frame's sum contains only that frame's operands. Nothing from an earlier frame carries over.
- R9: With no load, the block stays idle and produces no valid pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Sample strobe; captures ops_i |
| ops_i | input | NUM_OPS*OP_W | Packed operands, operand k at bits [k*OP_W +: OP_W] |
| sum_o | output | OP_W+clog2(NUM_OPS) | Registered group sum |
| valid_o | output | 1 | One-cycle pulse marking a new sum_o |

## Verification
All-ones operands test the width of the sum. A design whose accumulator is too narrow would drop the top carry. Frames loaded back to back, including a small frame after a large one, test the accumulator restart. A design that kept adding instead of restarting would report a sum inflated by the previous frame. A design that refused a load in the last cycle of a frame would lose every other frame. Loads raised in the middle of a frame, and operands that keep changing after capture, would both corrupt or restart the running result in a design that does not gate its load or does not register its operands.

// File: rtl/sacc_pkg.sv
package sacc_pkg;
  // Width of a position counter that must reach n-1 (never zero bits).
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sacc_serializer.sv
module sacc_serializer #(
  parameter int NUM_OPS = 6,
  parameter int OP_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load_i,
  input  logic [NUM_OPS*OP_W-1:0] ops_i,
  output logic [OP_W-1:0]         op_o,
  output logic                    first_o,
  output logic                    last_o,
  output logic                    vld_o
);
  localparam int CNT_W = sacc_pkg::cnt_width(NUM_OPS);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(NUM_OPS - 1);

  logic [OP_W-1:0]  stage_q [NUM_OPS];
  logic [CNT_W-1:0] pos_q;
  logic             active_q;
  logic             at_end;
  logic             take;

  assign at_end = active_q && (pos_q == LAST_POS);
  // A new frame may start when idle or while the final operand drains.
  assign take   = load_i && (!active_q || at_end);

  // Parallel load, then shift toward stage 0 one slot per cycle.
  for (genvar i = 0; i < NUM_OPS; i++) begin : g_stage
    if (i == NUM_OPS - 1) begin : g_tail
      always_ff @(posedge clk) begin
        if (take)          stage_q[i] <= ops_i[i*OP_W +: OP_W];
        else if (active_q) stage_q[i] <= '0;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (take)          stage_q[i] <= ops_i[i*OP_W +: OP_W];
        else if (active_q) stage_q[i] <= stage_q[i+1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      pos_q    <= '0;
    end else if (take) begin
      active_q <= 1'b1;
      pos_q    <= '0;
    end else if (active_q) begin
      if (at_end) begin
        active_q <= 1'b0;
        pos_q    <= '0;
      end else begin
        pos_q <= pos_q + CNT_W'(1);
      end
    end
  end

  assign op_o    = stage_q[0];
  assign vld_o   = active_q;
  assign first_o = active_q && (pos_q == '0);
  assign last_o  = at_end;
endmodule

// File: rtl/sacc_accum.sv
module sacc_accum #(
  parameter int OP_W  = 8,
  parameter int ACC_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  op_i,
  input  logic             first_i,
  input  logic             last_i,
  input  logic             vld_i,
  output logic [ACC_W-1:0] sum_o,
  output logic             valid_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_next;

  // The first operand of a frame replaces the running total.
  always_comb begin
    acc_next = (first_i ? '0 : acc_q) + ACC_W'(op_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      sum_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= vld_i && last_i;
      if (vld_i) acc_q <= acc_next;
      if (vld_i && last_i) sum_o <= acc_next;
    end
  end
endmodule

// File: rtl/serial_moa.sv
module serial_moa #(
  parameter int NUM_OPS = 6,
  parameter int OP_W    = 8,
  localparam int ACC_W  = OP_W + $clog2(NUM_OPS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load_i,
  input  logic [NUM_OPS*OP_W-1:0] ops_i,
  output logic [ACC_W-1:0]        sum_o,
  output logic                    valid_o
);
  logic [OP_W-1:0] ser_op;
  logic            ser_first;
  logic            ser_last;
  logic            ser_vld;

  sacc_serializer #(.NUM_OPS(NUM_OPS), .OP_W(OP_W)) u_ser (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .ops_i   (ops_i),
    .op_o    (ser_op),
    .first_o (ser_first),
    .last_o  (ser_last),
    .vld_o   (ser_vld)
  );

  sacc_accum #(.OP_W(OP_W), .ACC_W(ACC_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .op_i    (ser_op),
    .first_i (ser_first),
    .last_i  (ser_last),
    .vld_i   (ser_vld),
    .sum_o   (sum_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/sacc_chk.sv
module sacc_chk #(
  parameter int NUM_OPS = 6,
  parameter int OP_W    = 8,
  localparam int ACC_W  = OP_W + $clog2(NUM_OPS)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    load_i,
  input logic [NUM_OPS*OP_W-1:0] ops_i,
  input logic [ACC_W-1:0]        sum_o,
  input logic                    valid_o
);
  localparam int CNT_W = sacc_pkg::cnt_width(NUM_OPS);

  function automatic logic [ACC_W-1:0] group_sum(input logic [NUM_OPS*OP_W-1:0] v);
    logic [ACC_W-1:0] s = '0;
    for (int k = 0; k < NUM_OPS; k++) s = s + ACC_W'(v[k*OP_W +: OP_W]);
    return s;
  endfunction

  logic             busy_m;
  logic [CNT_W-1:0] age_m;
  logic             done_m;
  logic [ACC_W-1:0] exp_m;
  logic [ACC_W-1:0] done_exp;
  logic             end_m;

  assign end_m = busy_m && (age_m == CNT_W'(NUM_OPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_m   <= 1'b0;
      age_m    <= '0;
      done_m   <= 1'b0;
      exp_m    <= '0;
      done_exp <= '0;
    end else begin
      done_m <= end_m;
      if (end_m) done_exp <= exp_m;
      if (load_i && (!busy_m || end_m)) begin
        busy_m <= 1'b1;
        age_m  <= '0;
        exp_m  <= group_sum(ops_i);
      end else if (busy_m) begin
        busy_m <= !end_m;
        age_m  <= end_m ? '0 : age_m + CNT_W'(1);
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!valid_o && sum_o == '0));
  // R3
  valid_timing_chk: assert property (@(posedge clk) disable iff (rst) valid_o == done_m);
  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (NUM_OPS > 1 && valid_o) |=> !valid_o);
  // R2
  sum_value_chk: assert property (@(posedge clk) disable iff (rst) valid_o |-> sum_o == done_exp);
  // R4
  sum_hold_chk: assert property (@(posedge clk) disable iff (rst) !valid_o |-> $stable(sum_o));
endmodule

bind serial_moa sacc_chk #(.NUM_OPS(NUM_OPS), .OP_W(OP_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .load_i  (load_i),
  .ops_i   (ops_i),
  .sum_o   (sum_o),
  .valid_o (valid_o)
);

// File: tb/sim_serial_moa.sv
module sim_serial_moa;
  localparam int CLK_PERIOD = 10;
  localparam int NOPS = 6;
  localparam int OPW  = 8;
  localparam int ACCW = OPW + $clog2(NOPS);
  localparam int TOT  = NOPS * OPW;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            load = 1'b0;
  logic [TOT-1:0]  ops = '0;
  logic [ACCW-1:0] sum;
  logic            valid;

  int n_run = 0;
  int n_fail = 0;

  // reference state
  logic            m_busy = 1'b0;
  int              m_cnt = 0;
  logic [TOT-1:0]  m_ops = '0;
  logic            m_valid = 1'b0;
  logic [ACCW-1:0] m_sum = '0;

  serial_moa #(.NUM_OPS(NOPS), .OP_W(OPW)) u0 (
    .clk(clk), .rst(rst), .load_i(load), .ops_i(ops), .sum_o(sum), .valid_o(valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [ACCW-1:0] ref_sum(input logic [TOT-1:0] v);
    logic [ACCW-1:0] s = '0;
    for (int k = 0; k < NOPS; k++) s = s + ACCW'(v[k*OPW +: OPW]);
    return s;
  endfunction

  function automatic logic [TOT-1:0] rnd_ops();
    logic [TOT-1:0] v;
    for (int k = 0; k < NOPS; k++) v[k*OPW +: OPW] = OPW'($urandom);
    return v;
  endfunction

  task automatic model_edge(input logic ld, input logic [TOT-1:0] v);
    logic done;
    if (rst) begin
      m_busy = 0; m_cnt = 0; m_valid = 0; m_sum = '0;
      return;
    end
    done = m_busy && (m_cnt == NOPS - 1);
    m_valid = done;
    if (done) m_sum = ref_sum(m_ops);
    if (ld && (!m_busy || done)) begin
      m_ops = v; m_busy = 1; m_cnt = 0;
    end else if (m_busy) begin
      if (done) m_busy = 0; else m_cnt++;
    end
  endtask

  // Apply inputs, pass one edge, check both outputs 1 time unit later.
  task automatic cyc(input logic ld, input logic [TOT-1:0] v, input string tag);
    load = ld; ops = v;
    @(posedge clk);
    model_edge(ld, v);
    #1;
    n_run++;
    if (valid !== m_valid) begin
      n_fail++;
      $display("FAIL R3 %s: valid_o=%0b expected %0b at %0t", tag, valid, m_valid, $time);
    end
    n_run++;
    if (sum !== m_sum) begin
      n_fail++;
      $display("FAIL %s: sum_o=%0d expected %0d at %0t", tag, sum, m_sum, $time);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, rnd_ops(), tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    // R1: reset dominates even with load raised
    for (int i = 0; i < 3; i++) cyc(1'b1, rnd_ops(), "R1");
    rst = 1'b0;
    cyc(1'b0, '0, "R1");
    // R9: idle produces nothing
    idle(5, "R9");
    // R2: all-ones boundary (max sum, no overflow)
    cyc(1'b1, '1, "R2");
    idle(NOPS + 2, "R7");
    // R2: all zeros after a full frame, R8 restart
    cyc(1'b1, '0, "R8");
    idle(NOPS + 2, "R4");
    // R5: loads mid-frame ignored
    cyc(1'b1, rnd_ops(), "R5");
    cyc(1'b0, rnd_ops(), "R5");
    cyc(1'b1, '1, "R5");
    cyc(1'b1, '1, "R5");
    idle(NOPS + 3, "R5");
    // R6/R8: back-to-back frames, large then small
    for (int f = 0; f < 12; f++) begin
      cyc(1'b1, (f % 2 == 0) ? '1 : rnd_ops(), "R6");
      for (int j = 1; j < NOPS; j++) cyc(1'b0, rnd_ops(), "R8");
    end
    idle(NOPS + 2, "R6");
    // random mix
    for (int i = 0; i < 3000; i++) cyc(($urandom % 3) == 0, rnd_ops(), "R2");
    idle(NOPS + 2, "R9");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule